// File: doc/BRIEF.md
# Masked-Write PHY Configuration Register

This block is a single 32-bit control register on a simple write/read bus. Only the low 16 bits hold state; the high 16 bits of every write word are a per-bit enable, so software can change one field without reading the register first. A low bit takes the written value only when its partner bit, sixteen places higher in the same word, is 1. A read returns the stored low half, with zeros in the upper half.

The stored bits drive a narrow PHY configuration port. A 6-bit configuration address sits at bits 6:1, a 4-bit configuration data value sits at bits 10:7, and bit 0 is a strobe. Software writes address and data first, then sets the strobe, then clears it. The block turns each 0-to-1 change of the stored strobe into a write pulse on the port that lasts one clock cycle. The port's address and data outputs show the stored fields alongside the pulse.

Top module: `cfgport_mreg`

## Requirements
- R1: On a write to the register address, low bit x (0 to 15) takes data bit x when write-word bit x+16 is 1, and keeps its previous value when bit x+16 is 0.
- R2: A synchronous active-low reset clears all 16 stored bits, so the read value is 0, the configuration outputs are 0 and no pulse is seen.
- R3: With `bus_addr` equal to the register address, `bus_rdata` is {16'h0, stored[15:0]}; at any other address it is 0.
- R4: Writes with `bus_we` low, or to any address other than the register address (default 8'h20), change no stored bit and produce no pulse.
- R5: `cfg_addr_o` always equals stored bits 6:1 and `cfg_data_o` always equals stored bits 10:7.
- R6: A write that changes stored bit 0 from 0 to 1 makes `cfg_wr_o` high for exactly the one clock cycle that follows the clock edge taking the write.
- R7: Writing 1 with its mask bit 16 to a strobe bit that is already 1 produces no pulse.
- R8: A write whose bits 31:16 are all zero changes no stored bit and produces no pulse.
- R9: Writing 0 to bit 0 with mask bit 16 set returns the strobe to 0 without a pulse, and a later 0-to-1 write pulses again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Write valid for the current cycle |
| bus_addr | input | 8 | Register address for write and read |
| bus_wdata | input | 32 | Write word: enable mask in 31:16, values in 15:0 |
| bus_rdata | output | 32 | Read data, stored low half with zero upper half |
| cfg_wr_o | output | 1 | One-cycle write pulse to the PHY configuration port |
| cfg_addr_o | output | 6 | PHY configuration address (stored bits 6:1) |
| cfg_data_o | output | 4 | PHY configuration data (stored bits 10:7) |

## Verification
A stored bit that takes a wrong value, for example one written despite a clear mask bit, shows on `bus_rdata` and on the configuration field outputs in the cycle right after the faulty write. A fault in the strobe history register shows as a missing, repeated or stretched `cfg_wr_o` pulse, also in that cycle or the next one. The stimulus mixes random masks and addresses with directed strobe sequences, so that each write is followed at once by a read compare and a pulse compare.

// File: rtl/mreg_pkg.sv
package mreg_pkg;
   localparam int WORD_W = 32;
   localparam int HALF_W = WORD_W / 2;
   localparam int STROBE_BIT = 0;
   localparam int FIELD_LSB = STROBE_BIT + 1;

   typedef enum logic {
      PULSE_COMB = 1'b0,
      PULSE_REG  = 1'b1
   } pulse_mode_e;
endpackage

// File: rtl/mreg_decode.sv
module mreg_decode #(
   parameter int BUS_AW = 8,
   parameter logic [BUS_AW-1:0] REG_ADDR = 8'h20,
   parameter int WORD_W = 32,
   localparam int HALF_W = WORD_W / 2
) (
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic              hit_o,
   output logic              wr_en_o,
   output logic [HALF_W-1:0] wr_val_o,
   output logic [HALF_W-1:0] wr_mask_o
);
   generate
      if (WORD_W % 2 != 0) begin : g_bad_word
         $error("mreg_decode: WORD_W must be even");
      end
   endgenerate

   always_comb begin
      hit_o     = (bus_addr == REG_ADDR);
      wr_en_o   = bus_we && hit_o;
      wr_val_o  = bus_wdata[HALF_W-1:0];
      wr_mask_o = bus_wdata[WORD_W-1:HALF_W];
   end
endmodule

// File: rtl/mreg_store.sv
module mreg_store #(
   parameter int HALF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [HALF_W-1:0] wr_val,
   input  logic [HALF_W-1:0] wr_mask,
   output logic [HALF_W-1:0] q
);
   generate
      if (HALF_W < 1) begin : g_bad_half
         $error("mreg_store: HALF_W must be positive");
      end
      for (genvar i = 0; i < HALF_W; i++) begin : g_bit
         logic take;
         assign take = wr_en & wr_mask[i];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q[i] <= 1'b0;
            end else if (take) begin
               q[i] <= wr_val[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mreg_strobe.sv
module mreg_strobe #(
   parameter int CFG_AW = 6,
   parameter int CFG_DW = 4,
   parameter mreg_pkg::pulse_mode_e MODE = mreg_pkg::PULSE_COMB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [CFG_AW-1:0] addr_in,
   input  logic [CFG_DW-1:0] data_in,
   output logic              wr_o,
   output logic [CFG_AW-1:0] addr_o,
   output logic [CFG_DW-1:0] data_o
);
   logic strobe_d;
   logic rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_d <= 1'b0;
      end else begin
         strobe_d <= strobe;
      end
   end

   assign rise = strobe & ~strobe_d;

   generate
      if (MODE == mreg_pkg::PULSE_COMB) begin : g_comb
         assign wr_o   = rise;
         assign addr_o = addr_in;
         assign data_o = data_in;
      end else begin : g_reg
         logic              wr_q;
         logic [CFG_AW-1:0] addr_q;
         logic [CFG_DW-1:0] data_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr_q   <= 1'b0;
               addr_q <= '0;
               data_q <= '0;
            end else begin
               wr_q   <= rise;
               addr_q <= addr_in;
               data_q <= data_in;
            end
         end
         assign wr_o   = wr_q;
         assign addr_o = addr_q;
         assign data_o = data_q;
      end
   endgenerate
endmodule

// File: rtl/cfgport_mreg.sv
module cfgport_mreg #(
   parameter int BUS_AW = 8,
   parameter logic [BUS_AW-1:0] REG_ADDR = 8'h20,
   parameter int CFG_AW = 6,
   parameter int CFG_DW = 4,
   parameter mreg_pkg::pulse_mode_e MODE = mreg_pkg::PULSE_COMB,
   localparam int WORD_W = mreg_pkg::WORD_W,
   localparam int HALF_W = mreg_pkg::HALF_W,
   localparam int ADDR_LSB = mreg_pkg::FIELD_LSB,
   localparam int DATA_LSB = ADDR_LSB + CFG_AW,
   localparam int USED_W = DATA_LSB + CFG_DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic              cfg_wr_o,
   output logic [CFG_AW-1:0] cfg_addr_o,
   output logic [CFG_DW-1:0] cfg_data_o
);
   generate
      if (USED_W > HALF_W) begin : g_bad_fields
         $error("cfgport_mreg: configuration fields exceed the stored half");
      end
      if (CFG_AW < 1 || CFG_DW < 1) begin : g_bad_widths
         $error("cfgport_mreg: field widths must be positive");
      end
   endgenerate

   logic              hit;
   logic              wr_en;
   logic [HALF_W-1:0] wr_val;
   logic [HALF_W-1:0] wr_mask;
   logic [HALF_W-1:0] low_q;

   mreg_decode #(
      .BUS_AW  (BUS_AW),
      .REG_ADDR(REG_ADDR),
      .WORD_W  (WORD_W)
   ) u_decode (
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .hit_o    (hit),
      .wr_en_o  (wr_en),
      .wr_val_o (wr_val),
      .wr_mask_o(wr_mask)
   );

   mreg_store #(
      .HALF_W(HALF_W)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_val (wr_val),
      .wr_mask(wr_mask),
      .q      (low_q)
   );

   mreg_strobe #(
      .CFG_AW(CFG_AW),
      .CFG_DW(CFG_DW),
      .MODE  (MODE)
   ) u_strobe (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (low_q[mreg_pkg::STROBE_BIT]),
      .addr_in(low_q[DATA_LSB-1:ADDR_LSB]),
      .data_in(low_q[USED_W-1:DATA_LSB]),
      .wr_o   (cfg_wr_o),
      .addr_o (cfg_addr_o),
      .data_o (cfg_data_o)
   );

   assign bus_rdata = hit ? {{HALF_W{1'b0}}, low_q} : '0;
endmodule

// File: rtl/cfgport_mreg_chk.sv
module cfgport_mreg_chk #(
   parameter int BUS_AW = 8,
   parameter logic [BUS_AW-1:0] REG_ADDR = 8'h20,
   parameter int WORD_W = 32,
   parameter bit COMB_MODE = 1'b1,
   localparam int HALF_W = WORD_W / 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [BUS_AW-1:0] bus_addr,
   input logic [WORD_W-1:0] bus_wdata,
   input logic [HALF_W-1:0] low_q,
   input logic              cfg_wr_o
);
   logic [HALF_W-1:0] mask_w;
   assign mask_w = bus_wdata[WORD_W-1:HALF_W];

   // R2: reset empties the stored half
   a_r2_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (low_q == '0));

   // R1: bits without their enable keep their value
   a_r1_unmasked_keep: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |=> (((low_q ^ $past(low_q)) & ~$past(mask_w)) == '0));

   // R4: writes aimed elsewhere leave state alone
   a_r4_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we || bus_addr != REG_ADDR) |=> ($stable(low_q) && !(COMB_MODE && cfg_wr_o)));

   // R8: empty mask does nothing
   a_r8_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && mask_w == '0) |=> $stable(low_q));

   // R6: raising the strobe launches a pulse in the next cycle
   a_r6_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (COMB_MODE && bus_we && bus_addr == REG_ADDR && mask_w[0] && bus_wdata[0] && !low_q[0])
      |=> cfg_wr_o);

   // R6: the pulse lasts one cycle only
   a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_o |=> !cfg_wr_o);

   // R9: dropping the strobe never pulses
   a_r9_fall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (COMB_MODE && $fell(low_q[0])) |-> !cfg_wr_o);
endmodule

bind cfgport_mreg cfgport_mreg_chk #(
   .BUS_AW   (BUS_AW),
   .REG_ADDR (REG_ADDR),
   .WORD_W   (WORD_W),
   .COMB_MODE(MODE == mreg_pkg::PULSE_COMB)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .low_q    (low_q),
   .cfg_wr_o (cfg_wr_o)
);

// File: tb/tb_cfgport_mreg.sv
module tb_cfgport_mreg;
   localparam logic [7:0] REG = 8'h20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        cfg_wr_o;
   logic [5:0]  cfg_addr_o;
   logic [3:0]  cfg_data_o;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [15:0] exp_low = 16'h0;

   always #5 clk = ~clk;

   cfgport_mreg dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_wr_o(cfg_wr_o),
      .cfg_addr_o(cfg_addr_o), .cfg_data_o(cfg_data_o)
   );

   function automatic logic [15:0] apply_mask(logic [15:0] old, logic [31:0] w);
      return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // one bus cycle, then compare read data, fields and pulse
   task automatic bus_write(logic we, logic [7:0] a, logic [31:0] w, string req);
      logic [15:0] nxt;
      logic        pulse;
      bit          hit;
      hit = we && (a == REG);
      nxt = hit ? apply_mask(exp_low, w) : exp_low;
      pulse = !exp_low[0] && nxt[0];
      @(negedge clk);
      check({req, " idle before write"}, {31'h0, cfg_wr_o}, 32'h0);
      bus_we = we; bus_addr = a; bus_wdata = w;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = REG; bus_wdata = 32'h0;
      exp_low = nxt;
      #1;
      check({req, " R3 read"}, bus_rdata, {16'h0, exp_low});
      check({req, " R6 pulse"}, {31'h0, cfg_wr_o}, {31'h0, pulse});
      check({req, " R5 fields"}, {22'h0, cfg_data_o, cfg_addr_o},
            {22'h0, exp_low[10:7], exp_low[6:1]});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R2: reset state
      check("R2 reset read", bus_rdata, 32'h0);
      check("R2 reset pulse", {31'h0, cfg_wr_o}, 32'h0);
      bus_addr = REG; #1;
      check("R2 reset read at reg", bus_rdata, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      // R1: field writes without read-modify-write
      bus_write(1'b1, REG, 32'hFFFF_A5A4, "R1 full");
      bus_write(1'b1, REG, 32'h0F00_0000, "R1 partial clear");
      bus_write(1'b1, REG, 32'h00F0_FFFF, "R1 partial set");
      // R8: empty mask
      bus_write(1'b1, REG, 32'h0000_FFFF, "R8 zero mask");
      bus_write(1'b1, REG, 32'h0000_0001, "R8 zero mask strobe");
      // R4: wrong address and no valid
      bus_write(1'b1, 8'h24, 32'hFFFF_FFFF, "R4 other addr");
      bus_write(1'b0, REG, 32'hFFFF_FFFF, "R4 no valid");
      // R3: other address reads zero
      @(negedge clk); bus_addr = 8'h21; #1;
      check("R3 other addr read", bus_rdata, 32'h0);
      bus_addr = REG;

      // R6/R7/R9: config sequence
      bus_write(1'b1, REG, 32'hFFFF_0000, "R9 clear all");
      bus_write(1'b1, REG, 32'h07FE_0426, "R5 set fields");
      bus_write(1'b1, REG, 32'h0001_0001, "R6 raise strobe");
      @(negedge clk); #1;
      check("R6 pulse ends", {31'h0, cfg_wr_o}, 32'h0);
      bus_write(1'b1, REG, 32'h0001_0001, "R7 strobe again");
      bus_write(1'b1, REG, 32'h0001_0000, "R9 drop strobe");
      bus_write(1'b1, REG, 32'h0001_0001, "R9 raise again");

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] w;
         logic [7:0]  a;
         logic        we;
         w = $urandom;
         case ($urandom_range(0, 3))
            0: w[31:16] = 16'h0;
            1: w[31:16] = 16'h0001;
            default: ;
         endcase
         a = ($urandom_range(0, 7) == 0) ? 8'($urandom) : REG;
         we = ($urandom_range(0, 9) != 0);
         bus_write(we, a, w, "R1 random");
      end

      // R2: reset after activity
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); #1;
      exp_low = 16'h0;
      check("R2 late reset read", bus_rdata, 32'h0);
      check("R2 late reset fields", {22'h0, cfg_data_o, cfg_addr_o}, 32'h0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule